// File: doc/BRIEF.md
# Five-Operation Integer ALU

The block is a combinational integer arithmetic-logic unit for a 32-bit datapath. Two operands and a 3-bit operation code go in. A 32-bit result, a zero flag and a signed overflow flag come out in the same cycle. It performs bitwise AND, bitwise OR, addition, subtraction, and a signed set-on-less-than. A decoder or instruction stage drives the operation code. An equality test is a subtraction followed by a look at the zero flag.

The datapath is a chain of identical one-bit slices joined by a ripple carry. Subtraction feeds the inverted second operand into the same adder and sets the carry into bit 0. The signed comparison reuses that subtraction. The most significant slice produces a "set" bit, which is routed back into the less-than input of bit 0. An output stage zeroes the result for operation codes that are not defined. It also derives the zero flag and gates the overflow flag.

Top module: `int_alu`

## Requirements
- R1: Code 3'b000 returns the bitwise AND of `a_i` and `b_i`.
- R2: Code 3'b001 returns the bitwise OR of `a_i` and `b_i`.
- R3: Code 3'b010 returns `a_i + b_i` modulo 2^32.
- R4: Code 3'b110 returns `a_i - b_i` modulo 2^32, computed as `a_i + ~b_i + 1`.
- R5: Code 3'b111 returns 1 in bit 0 when `a_i < b_i` as signed values, otherwise 0. Bits 31..1 are always 0. The answer stays correct when the internal subtraction overflows.
- R6: For the five defined codes, `zero_o` is 1 exactly when all 32 bits of `result_o` are 0.
- R7: For code 3'b010, `ovf_o` is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it.
- R8: For codes 3'b110 and 3'b111, `ovf_o` is 1 exactly when the operand sign bits differ and the difference's sign bit differs from `a_i[31]`. An addition of operands with opposite signs never sets `ovf_o`. A subtraction of operands with equal signs never sets `ovf_o`.
- R9: For codes 3'b000 and 3'b001, `ovf_o` is 0.
- R10: Codes 3'b011, 3'b100 and 3'b101 give `result_o` = 0, `zero_o` = 0 and `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 3 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros (defined codes only) |
| ovf_o | output | 1 | Signed overflow of add, subtract or compare |

## Verification
Several properties are checked on every input change. Bits 31..1 of a comparison result stay 0. Undefined codes produce all-zero outputs. The logic operations never raise overflow. A raised zero flag implies a zero result. Overflow is never raised for an addition of opposite-sign operands or a subtraction of same-sign operands, and a raised addition overflow always matches the sign rule. What the assertions cannot show is that the result values are numerically right. That includes the comparison near the signed limits, where the difference wraps. Only the bench can show this, by comparing against its reference model on directed corner vectors and on a pseudo-random sweep of all eight codes.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int unsigned ALU_OP_W = 3;

  typedef enum logic [ALU_OP_W-1:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  // per-slice output selector, taken from the low two code bits
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  typedef struct packed {
    logic       valid;   // code is one of the five defined operations
    logic       b_neg;   // invert b and force carry-in of bit 0
    logic       arith;   // overflow flag is meaningful
    slice_sel_e sel;
  } alu_ctrl_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
  import int_alu_pkg::*;
(
  input  logic [ALU_OP_W-1:0] op_i,
  output alu_ctrl_t           ctrl_o
);

  logic known;

  always_comb begin
    known = (op_i inside {ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT});
    ctrl_o.valid = known;
    ctrl_o.b_neg = known & op_i[2];
    ctrl_o.arith = known & op_i[1];
    ctrl_o.sel   = slice_sel_e'(op_i[1:0]);
  end

endmodule

// File: rtl/int_alu_slice.sv
module int_alu_slice
  import int_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       b_neg_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       set_o,
  output logic       ovf_o
);

  logic b_eff;
  logic sum;

  always_comb begin
    b_eff  = b_i ^ b_neg_i;
    sum    = a_i ^ b_eff ^ cin_i;
    cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
    // carry into and out of a sign slice disagree only on signed overflow
    ovf_o  = cin_i ^ cout_o;
    // true sign of the full-precision difference
    set_o  = sum ^ ovf_o;
    case (sel_i)
      SEL_AND:  res_o = a_i & b_eff;
      SEL_OR:   res_o = a_i | b_eff;
      SEL_SUM:  res_o = sum;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  alu_ctrl_t        ctrl_i,
  input  logic [WIDTH-1:0] raw_i,
  input  logic             msb_ovf_i,
  input  logic [ALU_OP_W-1:0] op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);

  always_comb begin
    result_o = ctrl_i.valid ? raw_i : '0;
    zero_o   = ctrl_i.valid & ~(|raw_i);
    ovf_o    = ctrl_i.arith & msb_ovf_i;
  end

  always_comb begin
    if (!$isunknown(op_i)) begin
      // R6
      zero_flag_chk: assert (!zero_o || (result_o == '0))
        else $error("zero flag raised with nonzero result");
      // R10
      unused_code_chk: assert (!(op_i inside {3'b011, 3'b100, 3'b101}) ||
                               (result_o == '0 && !zero_o && !ovf_o))
        else $error("undefined code produced nonzero outputs");
      // R9
      logic_no_ovf_chk: assert (!(op_i inside {ALU_AND, ALU_OR}) || !ovf_o)
        else $error("overflow raised on a logic operation");
    end
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]    a_i,
  input  logic [WIDTH-1:0]    b_i,
  input  logic [ALU_OP_W-1:0] op_i,
  output logic [WIDTH-1:0]    result_o,
  output logic                zero_o,
  output logic                ovf_o
);

  localparam int unsigned MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] raw;
  logic             msb_set;
  logic             msb_ovf;

  int_alu_decode u_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : gen_slice
    logic ci;
    logic co;
    logic rb;
    logic less;
    logic set_b;
    logic ovf_b;

    if (i == 0) begin : g_first
      assign ci   = ctrl.b_neg;
      assign less = msb_set;
    end else begin : g_rest
      assign ci   = gen_slice[i-1].co;
      assign less = 1'b0;
    end

    int_alu_slice u_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .b_neg_i (ctrl.b_neg),
      .cin_i   (ci),
      .less_i  (less),
      .sel_i   (ctrl.sel),
      .res_o   (rb),
      .cout_o  (co),
      .set_o   (set_b),
      .ovf_o   (ovf_b)
    );

    assign raw[i] = rb;

    if (i == MSB) begin : g_sign
      assign msb_set = set_b;
      assign msb_ovf = ovf_b;
    end else begin : g_body
      logic unused_set;
      logic unused_ovf;
      assign unused_set = set_b;
      assign unused_ovf = ovf_b;
    end
  end

  int_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .ctrl_i    (ctrl),
    .raw_i     (raw),
    .msb_ovf_i (msb_ovf),
    .op_i      (op_i),
    .result_o  (result_o),
    .zero_o    (zero_o),
    .ovf_o     (ovf_o)
  );

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i})) begin
      // R5
      slt_upper_chk: assert (op_i != ALU_SLT || result_o[MSB:1] == '0)
        else $error("compare result has upper bits set");
      // R8
      no_overflow_chk: assert (!((op_i == ALU_ADD && a_i[MSB] != b_i[MSB]) ||
                                 (op_i inside {ALU_SUB, ALU_SLT} &&
                                  a_i[MSB] == b_i[MSB])) || !ovf_o)
        else $error("overflow where operand signs exclude it");
      // R7
      add_ovf_chk: assert (!(op_i == ALU_ADD && ovf_o) ||
                           (a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB]))
        else $error("add overflow without sign change");
    end
  end

endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;

  logic        clk;
  logic [31:0] a, b;
  logic [2:0]  op;
  logic [31:0] result;
  logic        zero, ovf;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int_alu u_int_alu (
    .a_i      (a),
    .b_i      (b),
    .op_i     (op),
    .result_o (result),
    .zero_o   (zero),
    .ovf_o    (ovf)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  op;
    logic [31:0] res;
    logic        z;
    logic        v;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [0:NV-1] = '{
    '{32'hF0F0_1234, 32'h0FF0_FF00, 3'b000, 32'h00F0_1200, 1'b0, 1'b0, 4'd1},  // R1
    '{32'hF000_0000, 32'h0000_000F, 3'b001, 32'hF000_000F, 1'b0, 1'b0, 4'd2},  // R2
    '{32'd7,         32'd6,         3'b010, 32'd13,        1'b0, 1'b0, 4'd3},  // R3
    '{32'h7FFF_FFFF, 32'd2,         3'b010, 32'h8000_0001, 1'b0, 1'b1, 4'd7},  // R7
    '{32'h8000_0000, 32'h8000_0000, 3'b010, 32'h0,         1'b1, 1'b1, 4'd7},  // R7
    '{32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b010, 32'h7FFF_FFFE, 1'b0, 1'b0, 4'd8},  // R8
    '{32'd7,         32'd6,         3'b110, 32'd1,         1'b0, 1'b0, 4'd4},  // R4
    '{32'd6,         32'd7,         3'b110, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'd4},  // R4
    '{32'h8000_0001, 32'd2,         3'b110, 32'h7FFF_FFFF, 1'b0, 1'b1, 4'd8},  // R8
    '{32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110, 32'h8000_0000, 1'b0, 1'b1, 4'd8},  // R8
    '{32'd5,         32'd5,         3'b110, 32'h0,         1'b1, 1'b0, 4'd6},  // R6
    '{32'h8000_0000, 32'h8000_0000, 3'b110, 32'h0,         1'b1, 1'b0, 4'd8},  // R8
    '{32'hFFFF_FFFF, 32'd1,         3'b111, 32'd1,         1'b0, 1'b0, 4'd5},  // R5
    '{32'd1,         32'hFFFF_FFFF, 3'b111, 32'd0,         1'b1, 1'b0, 4'd5},  // R5
    '{32'h8000_0000, 32'h7FFF_FFFF, 3'b111, 32'd1,         1'b0, 1'b1, 4'd5},  // R5
    '{32'h7FFF_FFFF, 32'h8000_0000, 3'b111, 32'd0,         1'b1, 1'b1, 4'd5},  // R5
    '{32'd3,         32'd3,         3'b111, 32'd0,         1'b1, 1'b0, 4'd5},  // R5
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'd9},  // R9
    '{32'h8000_0000, 32'h8000_0000, 3'b001, 32'h8000_0000, 1'b0, 1'b0, 4'd9},  // R9
    '{32'hFFFF_FFFF, 32'd1,         3'b011, 32'h0,         1'b0, 1'b0, 4'd10}, // R10
    '{32'hFFFF_FFFF, 32'd1,         3'b100, 32'h0,         1'b0, 1'b0, 4'd10}, // R10
    '{32'h7FFF_FFFF, 32'h8000_0000, 3'b101, 32'h0,         1'b0, 1'b0, 4'd10}  // R10
  };

  // behavioural reference built from the requirements
  function automatic void ref_alu(input logic [31:0] ra, input logic [31:0] rb,
                                  input logic [2:0] rop, output logic [31:0] rr,
                                  output logic rz, output logic rv);
    logic [31:0] d;
    logic        valid;
    valid = 1'b1;
    rv    = 1'b0;
    d     = ra - rb;
    case (rop)
      3'b000: rr = ra & rb;                                            // R1
      3'b001: rr = ra | rb;                                            // R2
      3'b010: begin                                                    // R3 R7
        rr = ra + rb;
        rv = (ra[31] == rb[31]) && (rr[31] != ra[31]);
      end
      3'b110: begin                                                    // R4 R8
        rr = d;
        rv = (ra[31] != rb[31]) && (d[31] != ra[31]);
      end
      3'b111: begin                                                    // R5
        rr = ($signed(ra) < $signed(rb)) ? 32'd1 : 32'd0;
        rv = (ra[31] != rb[31]) && (d[31] != ra[31]);
      end
      default: begin rr = '0; valid = 1'b0; end                        // R10
    endcase
    rz = valid && (rr == '0);                                          // R6
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input logic ez,
                       input logic ev);
    n_cmp++;
    if (result !== er || zero !== ez || ovf !== ev) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h: got res=%h z=%b v=%b, expected res=%h z=%b v=%b",
               tag, op, a, b, result, zero, ovf, er, ez, ev);
    end
  endtask

  task automatic apply(input logic [31:0] ta, input logic [31:0] tb,
                       input logic [2:0] top);
    @(negedge clk);
    a  = ta;
    b  = tb;
    op = top;
    #1;
  endtask

  initial begin
    logic [31:0] s, t, er;
    logic        ez, ev;
    a = '0; b = '0; op = 3'b000;
    #1;
    // initial state: zero operands under AND, R6
    check("R6 initial", 32'h0, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].op);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].res, VECS[i].z, VECS[i].v);
    end

    // directed: equality through subtract then zero flag, R6 and R4
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110);
    check("R6 equal", 32'h0, 1'b1, 1'b0);
    // directed: undefined code with all-zero operands keeps zero flag low, R10
    apply(32'h0, 32'h0, 3'b100);
    check("R10 zero operands", 32'h0, 1'b0, 1'b0);
    // directed: most negative vs itself compares not-less, R5
    apply(32'h8000_0000, 32'h8000_0000, 3'b111);
    check("R5 minint self", 32'h0, 1'b1, 1'b0);

    // pseudo-random sweep of every code against the reference
    s = 32'h1234_5678;
    t = 32'h9E37_79B9;
    for (int k = 0; k < 600; k++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      t = t ^ (t << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
      for (int c = 0; c < 8; c++) begin
        apply(s, (k % 5 == 0) ? s : t, 3'(c));
        ref_alu(a, b, op, er, ez, ev);
        check("R1..sweep", er, ez, ev);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule